// File: doc/BRIEF.md
# Preamble-Timed Frame Rate Tracker

This block works out the frame rate of an incoming digital audio stream. It uses nothing but a one-cycle strobe that an upstream biphase-mark decoder raises at each frame preamble. Between two consecutive strobes it counts reference clock cycles. Data transitions inside the frame never reach it, so the audio payload cannot move the measurement.

There are two modes. In acquisition mode the block accepts any period the counter can hold, so it needs no setup for different sample rates. It declares lock once a run of consecutive measurements agree closely, and it keeps the last of them as the nominal period. In tracking mode a new measurement is accepted only while it stays within one eighth of that nominal. A measurement outside that window, a missing stream or a fresh start of the enable sends the block back to acquisition, where it captures a new nominal.

Top module: `rate_tracker`

## Requirements
- R1: While reset is high or `run` is low, `locked`, `tracking`, `nominal` and `measured` are all 0, and strobes have no effect on them.
- R2: A measured period is the number of reference clock cycles between two consecutive strobe cycles. `measured` takes that value after the second strobe and changes at no other time. The first strobe after reset, after `run` rises or after a counter saturation only starts timing.
- R3: Acquisition counts measurements that each lie within (previous >> 3) of the one before. The first measurement counts as 1. On the 4th agreeing measurement, `locked` and `tracking` go to 1 and `nominal` takes that 4th value.
- R4: Lock is reached at periods far apart (for example 101 and 210 cycles) with no configuration change.
- R5: While locked, a measurement m with |m - nominal| <= nominal >> 3 keeps the lock. `nominal` stays unchanged and `measured` takes m.
- R6: While locked, a measurement outside that window clears `locked`, `tracking` and `nominal`. It then counts as the first measurement of a new acquisition.
- R7: While locked, if no strobe arrives before the cycle count since the last strobe reaches 2 x `nominal`, lock is dropped and acquisition restarts.
- R8: The cycle counter saturates at 2^16 - 1. Saturation resets the acquisition count, and the next strobe only starts timing.
- R9: After `run` rises, the block acquires afresh and may lock to a rate unrelated to any earlier nominal.
- R10: During acquisition, a measurement outside (previous >> 3) of the one before restarts the agreement count at 1, with itself as the new reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable; low holds the block idle |
| pre_stb | input | 1 | One-cycle strobe at each frame preamble |
| locked | output | 1 | Lock flag |
| tracking | output | 1 | Mode: 1 tracking, 0 acquisition |
| nominal | output | 16 | Captured nominal period in cycles, 0 when unlocked |
| measured | output | 16 | Latest measured period in cycles |

## Verification
Some rules are checked by assertions on every cycle: the idle state forced by a low `run`, a nominal that does not move while lock is held, the captured nominal at the moment lock rises, the drop after an out-of-window measurement or an expired gap, and measurements that are never zero. Other behaviour only shows up in the bench's scenarios. That includes the chained agreement count and its restart, window edges hit exactly at nominal >> 3, timing that is only armed after a saturation, and fresh acquisition to an unrelated rate after `run` toggles.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic {
    ST_ACQ = 1'b0,
    ST_TRK = 1'b1
  } trk_state_e;
endpackage

// File: rtl/period_counter.sv
module period_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         stb,
  output logic         meas_vld,
  output logic [W-1:0] meas,
  output logic [W-1:0] cur,
  output logic         sat
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         armed;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed    <= 1'b0;
      cnt      <= '0;
      meas_vld <= 1'b0;
      meas     <= '0;
      sat      <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      sat      <= 1'b0;
      if (stb) begin
        cnt   <= '0;
        armed <= 1'b1;
        if (armed) begin
          meas_vld <= 1'b1;
          meas     <= (cnt == MAXV) ? MAXV : cnt + 1'b1;
        end
      end else if (armed) begin
        if (cnt == MAXV) begin
          armed <= 1'b0;
          sat   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign cur = cnt;

  a_r2_meas_nonzero: assert property (@(posedge clk) disable iff (rst)
    meas_vld |-> (meas != '0));

  a_r8_sat_disarms: assert property (@(posedge clk) disable iff (rst)
    sat |=> !meas_vld);
endmodule

// File: rtl/window_chk.sv
module window_chk #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] base,
  output logic         ok
);
  logic [W-1:0] diff;

  always_comb begin
    diff = (val >= base) ? (val - base) : (base - val);
    ok   = (diff <= (base >> 3));
  end
endmodule

// File: rtl/rate_tracker.sv
module rate_tracker #(
  parameter int CNT_W   = 16,
  parameter int AGREE_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_stb,
  output logic             locked,
  output logic             tracking,
  output logic [CNT_W-1:0] nominal,
  output logic [CNT_W-1:0] measured
);
  import rt_pkg::*;

  localparam int AG_W = $clog2(AGREE_N + 1);
  localparam logic [AG_W-1:0] AG_LAST = AG_W'(AGREE_N - 1);

  logic             meas_vld, sat, ok_cand, ok_nom, timeout;
  logic [CNT_W-1:0] meas_w, cur_w, cand;
  logic [AG_W-1:0]  agree;
  trk_state_e       state;

  period_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(run), .stb(pre_stb),
    .meas_vld(meas_vld), .meas(meas_w), .cur(cur_w), .sat(sat)
  );

  window_chk #(.W(CNT_W)) u_win_cand (.val(meas_w), .base(cand),    .ok(ok_cand));
  window_chk #(.W(CNT_W)) u_win_nom  (.val(meas_w), .base(nominal), .ok(ok_nom));

  assign timeout = ({1'b0, cur_w} >= {nominal, 1'b0});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state    <= ST_ACQ;
      locked   <= 1'b0;
      nominal  <= '0;
      measured <= '0;
      cand     <= '0;
      agree    <= '0;
    end else begin
      if (meas_vld) measured <= meas_w;
      case (state)
        ST_ACQ: begin
          if (sat) begin
            agree <= '0;
          end else if (meas_vld) begin
            cand <= meas_w;
            if (agree == '0 || !ok_cand) begin
              agree <= AG_W'(1);
            end else if (agree == AG_LAST) begin
              state   <= ST_TRK;
              locked  <= 1'b1;
              nominal <= meas_w;
              agree   <= '0;
            end else begin
              agree <= agree + 1'b1;
            end
          end
        end
        default: begin
          if (sat || timeout) begin
            state   <= ST_ACQ;
            locked  <= 1'b0;
            nominal <= '0;
            agree   <= '0;
          end else if (meas_vld && !ok_nom) begin
            state   <= ST_ACQ;
            locked  <= 1'b0;
            nominal <= '0;
            agree   <= AG_W'(1);
            cand    <= meas_w;
          end
        end
      endcase
    end
  end

  assign tracking = (state == ST_TRK);

  a_r1_run_low_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!locked && !tracking && nominal == '0 && measured == '0));

  a_r3_lock_takes_last: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (nominal == meas_w && nominal != '0));

  a_r5_nominal_held: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(nominal));

  a_r6_window_drop: assert property (@(posedge clk) disable iff (rst)
    (run && tracking && meas_vld && !ok_nom) |=> !locked);

  a_r7_gap_drop: assert property (@(posedge clk) disable iff (rst)
    (run && tracking && !pre_stb && timeout) |=> !locked);

  a_r2_measured_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(measured) |-> ($past(meas_vld) || !$past(run)));
endmodule

// File: tb/rate_tracker_test.sv
module rate_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        pre_stb = 1'b0;
  logic        locked, tracking;
  logic [15:0] nominal, measured;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rate_tracker uut (
    .clk(clk), .rst(rst), .run(run), .pre_stb(pre_stb),
    .locked(locked), .tracking(tracking), .nominal(nominal), .measured(measured)
  );

  // period, expected locked, expected nominal, expected measured
  localparam int NV = 15;
  localparam int VEC [NV][4] = '{
    '{100, 0,   0, 100},  // R3 first
    '{104, 0,   0, 104},
    '{ 98, 0,   0,  98},
    '{101, 1, 101, 101},  // R3 R4 lock on 4th
    '{112, 1, 101, 112},  // R5 +11 inside
    '{ 89, 1, 101,  89},  // R5 -12 on edge
    '{114, 0,   0, 114},  // R6 +13 outside
    '{120, 0,   0, 120},
    '{118, 0,   0, 118},
    '{200, 0,   0, 200},  // R10 restart
    '{205, 0,   0, 205},
    '{195, 0,   0, 195},
    '{210, 1, 210, 210},  // R4 lock at other rate
    '{236, 1, 210, 236},  // R5 +26 on edge
    '{237, 0,   0, 237}   // R6 +27 outside
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int l, input int n, input int m);
    chk({tag, " locked"}, int'(locked), l);
    chk({tag, " tracking"}, int'(tracking), l);
    chk({tag, " nominal"}, int'(nominal), n);
    chk({tag, " measured"}, int'(measured), m);
  endtask

  // strobe p cycles after the previous one, then let two cycles settle
  task automatic gap(input int p);
    repeat (p - 3) @(negedge clk);
    pre_stb = 1'b1;
    @(negedge clk);
    pre_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 run low", 0, 0, 0);
    run = 1'b1;
    gap(10);
    chk_all("R2 arming strobe", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      gap(VEC[i][0]);
      chk_all($sformatf("R3 vec%0d", i), VEC[i][1], VEC[i][2], VEC[i][3]);
    end

    for (int i = 0; i < 4; i++) gap(50);
    chk_all("R3 relock 50", 1, 50, 50);
    repeat (77) @(negedge clk);
    chk("R7 before gap limit", int'(locked), 1);
    repeat (30) @(negedge clk);
    chk_all("R7 gap expired", 0, 0, 50);

    repeat (66000) @(negedge clk);
    gap(3);
    chk_all("R8 strobe after saturation", 0, 0, 50);
    for (int i = 0; i < 3; i++) gap(300);
    chk_all("R8 three after saturation", 0, 0, 300);
    gap(300);
    chk_all("R8 lock 300", 1, 300, 300);

    @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R9 run low", 0, 0, 0);
    pre_stb = 1'b1;
    @(negedge clk);
    pre_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1 strobe ignored", 0, 0, 0);
    run = 1'b1;
    gap(5);
    chk_all("R9 arm after run", 0, 0, 0);
    for (int i = 0; i < 4; i++) gap(150);
    chk_all("R9 fresh lock 150", 1, 150, 150);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule